// File: doc/BRIEF.md
# Watchdog Timer with Protected Turn-Off

This block is a supervisor timer for a processor subsystem. Once software turns it on, it counts clock cycles. If software does not issue a restart strobe before the count reaches the selected timeout, the block raises a one-cycle reset request for the chip. The timeout is chosen from eight lengths that double at each step. The shortest length is set by a parameter, so a simulation build can use short periods while a silicon build uses the full ones.

Software talks to the block through two byte-wide registers.

- **Control register.** It holds the run bit, an unlock bit and the timeout select.
- **Status register.** It keeps a sticky flag that records a watchdog-caused reset until software clears it.

A stray write must not be able to stop the watchdog. Turning it off therefore takes two writes. The first write sets the unlock bit and the run bit together. This opens a short window that closes by itself. A write that clears the run bit within that window stops the timer. Outside the window, such a write leaves the timer running.

Top module: `wdog_guard`

## Requirements
- R1: After a synchronous reset, both register read ports are zero and the reset request output is low.
- R2: Control bit 4 is the unlock bit, bit 3 the run bit and bits 2:0 the timeout select. Bits 7:5 read as zero. A write of 0xE3 with the timer stopped reads back 0x03.
- R3: For select value s, the reset request rises exactly 2^(BASE_SHIFT+s) cycles after the write that started the timer.
- R4: The reset request is high for one cycle only. Afterwards the count restarts from zero, the run bit stays set, and the next request follows after one full timeout.
- R5: A restart strobe clears the count. Strobes spaced closer than the timeout prevent any request. After the last strobe, the request comes one full timeout later.
- R6: A write with bits 4 and 3 both one sets the unlock bit. The unlock bit reads one after that write and for three more cycles, then reads zero without further writes.
- R7: A write with bit 3 at zero, made 1 to 4 cycles after the unlocking write, stops the timer and clears the unlock bit at once.
- R8: A write with bit 3 at zero while the unlock bit reads zero leaves the run bit set, but still updates the timeout select. A write with only bit 4 set (no bit 3) does not open the window.
- R9: While stopped, no request is raised and the count is held at zero. A later start counts a full timeout from zero.
- R10: A reset request sets status bit 3. All other status bits read zero.
- R11: Writing the status register with bit 3 at zero clears the flag. Writing it with bit 3 at one leaves the flag as it was. A request in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high chip reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status register write data |
| stat_rdata | output | 8 | Status register read data |
| kick | input | 1 | Restart strobe that clears the count |
| wd_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `BASE_SHIFT` is at least one, so that a request can never be followed directly by another. They also assume that the write strobes and the restart strobe are clean single-cycle levels, sampled at the rising edge.

The bench drives every input half a cycle after the edge. It uses a BASE_SHIFT of 3, which keeps every timeout length short enough to sweep in full. It uses the longest select while it probes the unlock window, so that no request can land inside that sequence. Only one test lines up a status write with the exact firing edge on purpose.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int REG_W         = 8;
    localparam int SEL_W         = 3;
    localparam int UNLOCK_CYCLES = 4;
    localparam int FLAG_BIT      = 3;

    // Control fields; packed order places unlock at bit 4, run at 3, select at 2:0
    typedef struct packed {
        logic             unlock;
        logic             run;
        logic [SEL_W-1:0] sel;
    } wd_ctl_t;

    function automatic wd_ctl_t ctl_decode(input logic [REG_W-1:0] b);
        wd_ctl_t c;
        c.unlock = b[4];
        c.run    = b[3];
        c.sel    = b[SEL_W-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctl_encode(input wd_ctl_t c);
        return {3'b000, c.unlock, c.run, c.sel};
    endfunction

endpackage

// File: rtl/wdog_ctl.sv
module wdog_ctl
    import wdog_pkg::*;
#(
    parameter int WINDOW = UNLOCK_CYCLES
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  wd_ctl_t wdata,
    output wd_ctl_t state
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    logic             run_q, run_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    logic [WIN_W-1:0] win_q, win_d;
    logic             win_open;

    assign win_open = (win_q != '0);

    always_comb begin
        run_d = run_q;
        sel_d = sel_q;
        win_d = win_open ? win_q - WIN_W'(1) : win_q;
        if (wr) begin
            sel_d = wdata.sel;
            if (wdata.unlock && wdata.run) begin
                run_d = 1'b1;
                win_d = WIN_W'(WINDOW);
            end else if (wdata.run) begin
                run_d = 1'b1;
            end else if (win_open) begin
                run_d = 1'b0;
                win_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            sel_q <= '0;
            win_q <= '0;
        end else begin
            run_q <= run_d;
            sel_q <= sel_d;
            win_q <= win_d;
        end
    end

    assign state.unlock = win_open;
    assign state.run    = run_q;
    assign state.sel    = sel_q;

    // R6: the window closes by itself after its last open cycle
    assert_window_expires_R6: assert property (@(posedge clk) disable iff (rst)
        (win_q == WIN_W'(1) && !(wr && wdata.unlock && wdata.run)) |=> !win_open);

    // R8: a clearing write with the window shut keeps the timer running
    assert_locked_run_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata.run && run_q && !win_open) |=> run_q);

    // R7: a clearing write inside the window stops the timer
    assert_unlocked_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata.run && win_open) |=> (!run_q && !win_open));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             kick,
    output logic             fire,
    output logic             req
);
    localparam int CNT_W = BASE_SHIFT + (1 << SEL_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;

    assign last_q = (CNT_W'(1) << (BASE_SHIFT + int'(sel))) - CNT_W'(1);
    assign fire   = run && !kick && (cnt_q >= last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req   <= 1'b0;
        end else begin
            req <= fire;
            if (!run || kick || fire) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R4: a request never lasts two cycles
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R5: a restart strobe empties the count and blocks the request
    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0 && !req));

    // R9: nothing fires while stopped
    assert_quiet_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!req && cnt_q == '0));

endmodule

// File: rtl/wdog_status.sv
module wdog_status
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic wr,
    input  logic wbit,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (fire) begin
            flag <= 1'b1;
        end else if (wr && !wbit) begin
            flag <= 1'b0;
        end
    end

    // R10: a timeout always leaves the flag set
    assert_flag_on_fire_R10: assert property (@(posedge clk) disable iff (rst)
        fire |=> flag);

    // R11: writing one to the flag position does not change it
    assert_write_one_keeps_R11: assert property (@(posedge clk) disable iff (rst)
        (wr && wbit && !fire) |=> $stable(flag));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int BASE_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic             stat_wr,
    input  logic [REG_W-1:0] stat_wdata,
    output logic [REG_W-1:0] stat_rdata,
    input  logic             kick,
    output logic             wd_req
);
    wd_ctl_t ctl_state;
    logic    fire;
    logic    flag;
    logic    unused_wbits;

    assign unused_wbits = ^{ctl_wdata[7:5], stat_wdata[7:4], stat_wdata[2:0]};

    wdog_ctl #(
        .WINDOW(UNLOCK_CYCLES)
    ) u_ctl (
        .clk  (clk),
        .rst  (rst),
        .wr   (ctl_wr),
        .wdata(ctl_decode(ctl_wdata)),
        .state(ctl_state)
    );

    wdog_counter #(
        .BASE_SHIFT(BASE_SHIFT)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .run (ctl_state.run),
        .sel (ctl_state.sel),
        .kick(kick),
        .fire(fire),
        .req (wd_req)
    );

    wdog_status u_stat (
        .clk (clk),
        .rst (rst),
        .fire(fire),
        .wr  (stat_wr),
        .wbit(stat_wdata[FLAG_BIT]),
        .flag(flag)
    );

    assign ctl_rdata  = ctl_encode(ctl_state);
    assign stat_rdata = REG_W'(flag) << FLAG_BIT;

    // R2: the unlock bit can only read one while the timer runs
    assert_unlock_implies_run_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[4] |-> ctl_rdata[3]);

endmodule

// File: tb/wdog_guard_test.sv
module wdog_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int BS         = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0, stat_wr = 1'b0, kick = 1'b0;
    logic [7:0] ctl_wdata = 8'h00, stat_wdata = 8'h00;
    logic [7:0] ctl_rdata, stat_rdata;
    logic       wd_req;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    wdog_guard #(.BASE_SHIFT(BS)) uut (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
        .kick(kick), .wd_req(wd_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic wr_stat(input logic [7:0] d);
        stat_wr = 1'b1; stat_wdata = d;
        step();
        stat_wr = 1'b0;
    endtask

    task automatic wait_req(input int maxc, output int n);
        n = 0;
        while (n <= maxc) begin
            step();
            n++;
            if (wd_req) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int lim;
        int seen;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        check("R1 ctl", ctl_rdata, 8'h00);
        check("R1 stat", stat_rdata, 8'h00);
        check("R1 req", wd_req, 0);

        // R2 upper bits ignored, run not set
        wr_ctl(8'hE3);
        check("R2 readback", ctl_rdata, 8'h03);

        // R3/R4/R10 sweep of every select
        for (int s = 0; s < 8; s++) begin
            lim = 1 << (BS + s);
            wr_ctl(8'h08 | 8'(s));
            wait_req(lim + 2, n);
            check("R3 timeout", n, lim);
            step();
            check("R4 pulse low", wd_req, 0);
            check("R4 run kept", ctl_rdata, 8'h08 | s);
            check("R10 flag", stat_rdata, 8'h08);
            wait_req(lim + 2, n);
            check("R4 period", n, lim - 1);
            wr_stat(8'h00);
            check("R11 clear", stat_rdata, 8'h00);
            wr_ctl(8'h18 | 8'(s));
            wr_ctl(8'(s));
            check("R7 stopped", ctl_rdata, s);
        end

        // R6/R7/R8 window timing, longest select
        for (int d = 1; d <= 5; d++) begin
            wr_ctl(8'h0F);
            wr_ctl(8'h1F);
            check("R6 unlock set", ctl_rdata, 8'h1F);
            for (int i = 1; i < d; i++) begin
                step();
                check("R6 unlock bit", ctl_rdata[4], (i <= 3) ? 1 : 0);
            end
            wr_ctl(8'h05);
            check(d <= 4 ? "R7 stop in window" : "R8 stop late", ctl_rdata,
                  d <= 4 ? 8'h05 : 8'h0D);
            if (d == 5) begin
                wr_ctl(8'h1D);
                wr_ctl(8'h05);
            end
        end

        // R8 without unlock
        wr_ctl(8'h0F);
        wr_ctl(8'h02);
        check("R8 sel updates run kept", ctl_rdata, 8'h0A);
        wr_ctl(8'h10);
        check("R8 unlock alone", ctl_rdata, 8'h08);
        wr_ctl(8'h00);
        check("R8 still running", ctl_rdata, 8'h08);
        wr_ctl(8'h18);
        wr_ctl(8'h00);
        check("R7 off", ctl_rdata, 8'h00);

        // R9 stopped is quiet, restart counts from zero
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (wd_req) seen++;
        end
        check("R9 no req stopped", seen, 0);
        wr_ctl(8'h08);
        repeat (5) step();
        wr_ctl(8'h18);
        wr_ctl(8'h00);
        repeat (3) step();
        wr_ctl(8'h08);
        wait_req(20, n);
        check("R9 fresh count", n, 8);

        // R5 restart strobes
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            kick = (i % 5 == 0);
            step();
            if (wd_req) seen++;
        end
        kick = 1'b0;
        check("R5 kicks hold off", seen, 0);
        kick = 1'b1;
        step();
        kick = 1'b0;
        wait_req(20, n);
        check("R5 after last kick", n, 8);

        // R11 flag write rules and priority
        wr_stat(8'h00);
        check("R11 cleared", stat_rdata, 8'h00);
        repeat (6) step();
        stat_wr = 1'b1; stat_wdata = 8'h00;
        step();
        stat_wr = 1'b0;
        check("R11 fire edge req", wd_req, 1);
        check("R11 fire beats clear", stat_rdata, 8'h08);
        wr_stat(8'h08);
        check("R11 write one keeps", stat_rdata, 8'h08);
        wr_stat(8'hF7);
        check("R11 write zero clears", stat_rdata, 8'h00);
        wr_stat(8'hFF);
        check("R11 write one no set", stat_rdata, 8'h00);

        // R1 reset mid-run
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 ctl after rst", ctl_rdata, 8'h00);
        check("R1 req after rst", wd_req, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule